// File: doc/BRIEF.md
# Subsystem Interrupt Flag Controller

This block gathers four internal event sources into sticky interrupt flags and drives one interrupt line toward the host. Each source is edge-detected; a rising edge sets its flag, and the flag then holds until the host clears it. Each flag has its own enable. The interrupt line is asserted while any flag is set and also enabled.

The host controls the block through one control word. The low nibble is a write-1-to-clear mask for the flags. The third nibble holds the per-source enables. A single write therefore both acknowledges events and sets the new enables. The host reads back one status word. It packs the live flags, a 3-bit monitor identifier, a configuration strap sampled while reset is held, and a 4-bit chip revision.

Top module: `irq_subsys_top`

## Requirements
- R1: A rising edge on `evtIn[i]` (low in one sampled cycle, high in the next) sets flag i on that clock edge. The flag then stays set whatever the source does, until it is cleared.
- R2: A control write with bit i (i = 0..3) at 1 clears flag i at that edge. Flags whose clear bit is 0 are left unchanged. Nothing else clears a flag apart from reset.
- R3: If a rising edge of source i and a clear of flag i land on the same edge, flag i ends up set.
- R4: Every control write loads the enables from control bits 8..11, with bit 8+i enabling source i. Without a write the enables hold their value.
- R5: `irqOut` is a register. After each edge it equals the OR over i of (flag i AND enable i), taken from the values held before that edge.
- R6: Control bits 4..7 and 12..15 are ignored. They change neither the flags nor the enables.
- R7: The status word is laid out as follows: bits 3..0 are the flags (0 vertical blank, 1 pick, 2 invalid I/O, 3 engine idle), bits 6..4 are `monitorId`, bit 7 is the latched strap, bits 11..8 are `chipRev`, and bits 15..12 read 0.
- R8: Status bit 7 is the value of `planeStrap` sampled while `rstN` is low. It does not follow later changes of the pin.
- R9: After reset, all flags, all enables and `irqOut` are 0.
- R10: A source held high sets its flag only once. After a clear, the flag stays 0 until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| evtIn | input | 4 | Event sources: vertical blank, pick, invalid I/O, engine idle |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 16 | Control word: clear mask in bits 3..0, enables in bits 11..8 |
| monitorId | input | 3 | Monitor identifier reported in status bits 6..4 |
| planeStrap | input | 1 | Configuration strap pin |
| chipRev | input | 4 | Revision reported in status bits 11..8 |
| statusWord | output | 16 | Packed status word |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The interrupt line is checked against all 256 combinations of flag pattern and enable pattern. This separates a correct per-source AND from swapped, missing or OR-ed enable bits. Every one of the 16 clear masks is applied to a full set of flags, with the ignored nibbles filled with ones, so that a wrong bit position or a leaking reserved bit shows up. Directed patterns cover a collision between a set and a clear, a source held high across a clear, a strap pin that moves after reset, and sweeps of the identifier and revision fields.

// File: rtl/irq_subsys_pkg.sv
package irq_subsys_pkg;
  localparam int NUM_SRC  = 4;
  localparam int WORD_W   = 16;
  localparam int CLR_LSB  = 0;
  localparam int EN_LSB   = 8;
  localparam int ID_W     = 3;
  localparam int REV_W    = 4;
  localparam int ID_LSB   = NUM_SRC;
  localparam int STRAP_BIT = ID_LSB + ID_W;
  localparam int REV_LSB  = STRAP_BIT + 1;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrMask;
    logic               enLoad;
    logic [NUM_SRC-1:0] enValue;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_subsys_ctrl.sv
module irq_subsys_ctrl
  import irq_subsys_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output ctlStrobe_t        strb
);
  always_comb begin
    strb.clrMask = '0;
    strb.enLoad  = 1'b0;
    strb.enValue = '0;
    if (wrEn) begin
      strb.clrMask = wrData[CLR_LSB +: NUM_SRC];
      strb.enLoad  = 1'b1;
      strb.enValue = wrData[EN_LSB +: NUM_SRC];
    end
  end

  // R2 / R4: no strobe leaves the decoder without a write
  p_quiet_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb.clrMask == '0) && !strb.enLoad);
endmodule

// File: rtl/irq_subsys_datapath.sv
module irq_subsys_datapath
  import irq_subsys_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  ctlStrobe_t         strb,
  input  logic [ID_W-1:0]    monitorId,
  input  logic               planeStrap,
  input  logic [REV_W-1:0]   chipRev,
  output logic [WORD_W-1:0]  statusWord,
  output logic               irqOut
);
  localparam int PAD_W = WORD_W - REV_LSB - REV_W;

  logic [NUM_SRC-1:0] evtPrevQ;
  logic [NUM_SRC-1:0] riseEvt;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic               strapQ;
  logic               irqQ;

  assign riseEvt = evtIn & ~evtPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) evtPrevQ <= '0;
    else       evtPrevQ <= evtIn;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)           flagQ[i] <= 1'b0;
      else if (riseEvt[i]) flagQ[i] <= 1'b1;
      else if (strb.clrMask[i]) flagQ[i] <= 1'b0;
    end

    // R1: a set flag without a clear stays set
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[i] && !strb.clrMask[i] |=> flagQ[i]);
    // R3: an edge always leaves the flag set, even against a clear
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
      riseEvt[i] |=> flagQ[i]);
    // R2: a clear with no edge drops the flag
    p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrMask[i] && !riseEvt[i] |=> !flagQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           enQ <= '0;
    else if (strb.enLoad) enQ <= strb.enValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= planeStrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(flagQ & enQ);
  end

  assign irqOut = irqQ;
  assign statusWord = {{PAD_W{1'b0}}, chipRev, strapQ, monitorId, flagQ};

  // R4: enables hold without a load
  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enLoad |=> $stable(enQ));
  // R5: irq follows enabled flags one edge later
  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagQ & enQ)) |=> irqOut);
  p_irq_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(|(flagQ & enQ)) |=> !irqOut);
  // R8: strap is frozen once out of reset
  p_strap_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(strapQ));
endmodule

// File: rtl/irq_subsys_top.sv
module irq_subsys_top
  import irq_subsys_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  evtIn,
  input  logic                ctlWrEn,
  input  logic [WORD_W-1:0]   ctlWrData,
  input  logic [ID_W-1:0]     monitorId,
  input  logic                planeStrap,
  input  logic [REV_W-1:0]    chipRev,
  output logic [WORD_W-1:0]   statusWord,
  output logic                irqOut
);
  ctlStrobe_t strb;

  irq_subsys_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ctlWrEn),
    .wrData (ctlWrData),
    .strb   (strb)
  );

  irq_subsys_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .evtIn      (evtIn),
    .strb       (strb),
    .monitorId  (monitorId),
    .planeStrap (planeStrap),
    .chipRev    (chipRev),
    .statusWord (statusWord),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/tb_irq_subsys_top.sv
module tb_irq_subsys_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  evtIn;
  logic        ctlWrEn;
  logic [15:0] ctlWrData;
  logic [2:0]  monitorId;
  logic        planeStrap;
  logic [3:0]  chipRev;
  logic [15:0] statusWord;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  // model state, derived from the requirements
  logic [3:0] mFlag, mEn, mPrev;
  logic       mIrq, mStrap;

  always #5 clk = ~clk;

  irq_subsys_top dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .monitorId(monitorId), .planeStrap(planeStrap),
    .chipRev(chipRev), .statusWord(statusWord), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs driven at negedge, model advanced at posedge, back at negedge
  task automatic step(input logic [3:0] e, input logic w, input logic [15:0] d);
    logic [3:0] rise;
    evtIn = e; ctlWrEn = w; ctlWrData = d;
    @(posedge clk);
    rise  = e & ~mPrev;
    mIrq  = |(mFlag & mEn);
    mFlag = (mFlag & ~(w ? d[3:0] : 4'h0)) | rise;
    if (w) mEn = d[11:8];
    mPrev = e;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0; planeStrap = strap;
    evtIn = '0; ctlWrEn = 0; ctlWrData = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mFlag = 0; mEn = 0; mPrev = 0; mIrq = 0; mStrap = strap;
  endtask

  task automatic checkFlagsIrq(input string tag);
    chk({tag, " flags"}, {12'h0, statusWord[3:0]}, {12'h0, mFlag});
    chk({tag, " irq"}, {15'h0, irqOut}, {15'h0, mIrq});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        nFail++; nRun++;
        $display("FAIL watchdog: actual %0d cycles expected done", cycles);
        $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    monitorId = 3'd2; chipRev = 4'h5;
    doReset(1'b1);
    // R9 reset state
    chk("R9 status", statusWord, {4'h0, 4'h5, 1'b1, 3'd2, 4'h0});
    chk("R9 irq", {15'h0, irqOut}, 16'h0);
    step(4'h0, 0, 0);
    chk("R9 irq after idle", {15'h0, irqOut}, 16'h0);

    // R8: strap frozen after reset
    planeStrap = 1'b0; step(4'h0, 0, 0);
    chk("R8 strap held high", {15'h0, statusWord[7]}, 16'h1);
    doReset(1'b0); planeStrap = 1'b1; step(4'h0, 0, 0);
    chk("R8 strap held low", {15'h0, statusWord[7]}, 16'h0);

    // R7: id and revision fields
    for (int m = 0; m < 8; m++) begin
      monitorId = m[2:0]; chipRev = 4'(15 - m); #1;
      chk("R7 layout", statusWord, {4'h0, 4'(15 - m), 1'b0, m[2:0], mFlag});
    end
    for (int r = 8; r < 16; r++) begin
      chipRev = r[3:0]; #1;
      chk("R7 revision", {12'h0, statusWord[11:8]}, {12'h0, r[3:0]});
    end

    // R4 + R5: exhaustive flag x enable
    for (int f = 0; f < 16; f++) begin
      for (int en = 0; en < 16; en++) begin
        step(4'h0, 1, {4'h0, en[3:0], 4'h0, 4'hF});
        step(f[3:0], 0, 0);
        step(4'h0, 0, 0);
        step(4'h0, 0, 0);
        chk("R1 flags set by edges", {12'h0, statusWord[3:0]}, {12'h0, f[3:0]});
        chk("R5 irq from flags and enables", {15'h0, irqOut},
            {15'h0, |(f[3:0] & en[3:0])});
        checkFlagsIrq("R4 model");
      end
    end

    // R2 + R6: every clear mask, ignored nibbles filled
    for (int m = 0; m < 16; m++) begin
      step(4'h0, 1, 16'h0F0F);
      step(4'hF, 0, 0);
      step(4'h0, 0, 0);
      step(4'h0, 1, {4'hF, 4'hF, 4'hF, m[3:0]});
      chk("R2 clear mask", {12'h0, statusWord[3:0]}, {12'h0, ~m[3:0]});
      step(4'h0, 0, 0);
      chk("R6 reserved bits ignored", {15'h0, irqOut}, {15'h0, |(~m[3:0])});
      step(4'h0, 0, 0);
      chk("R1 flags hold", {12'h0, statusWord[3:0]}, {12'h0, ~m[3:0]});
    end

    // R3: set wins over clear on each source
    for (int i = 0; i < 4; i++) begin
      step(4'h0, 1, 16'h000F);
      step(4'(1 << i), 1, 16'h000F);
      chk("R3 set beats clear", {12'h0, statusWord[3:0]}, {12'h0, 4'(1 << i)});
      step(4'h0, 0, 0);
    end

    // R10: held source does not re-set after clear
    step(4'h0, 1, 16'h000F);
    step(4'h4, 0, 0);
    chk("R10 set once", {12'h0, statusWord[3:0]}, 16'h4);
    step(4'h4, 1, 16'h0004);
    step(4'h4, 0, 0);
    step(4'h4, 0, 0);
    chk("R10 stays clear while high", {12'h0, statusWord[3:0]}, 16'h0);
    step(4'h0, 0, 0);
    step(4'h4, 0, 0);
    chk("R10 new edge sets", {12'h0, statusWord[3:0]}, 16'h4);
    checkFlagsIrq("R10 model");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule